// File: doc/BRIEF.md
# Three-Byte Serial ADC Conversion Sequencer

This block is the host side of a serial link to an 8-bit sampling ADC that needs one control byte per conversion. On a start request it builds the control byte from a channel number and two mode flags, drives chip select low, and clocks 24 bits in SPI mode 0. Bits are launched while SCLK is low and sampled on the rising edge. The first byte sent is the control byte and the first byte received is thrown away. Two all-zero bytes follow. While they are sent, the reply bytes are captured. The reply carries the conversion result shifted across the byte boundary: two zero pad bits come before it and six zero pad bits follow it. The sequencer realigns the result, raises chip select and presents the result together with a one-cycle done pulse.

The SCLK half period and an optional idle gap between bytes are programmable in system clocks. Both are captured when the start request is accepted. The converter's sample droops if a conversion takes too long. For that reason a watchdog counts the system clocks of each conversion and flags an error when the count exceeds a budget. With a 100 MHz system clock the default budget equals 1 ms. The choice of divider should keep SCLK between 50 kHz and 500 kHz.

Top module: `adc_xfer_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o, mosi_o, busy_o, done_o and err_o are 0, and result_o is 0x00.
- R2: The first byte sent, MSB first, is {1, chan_i[2:0], unipolar_i, single_i, 1, 1}. Bit 7 is the start bit, bits 6..4 hold the channel, bit 3 is unipolar, bit 2 is single-ended, and bits 1..0 are both 1 to select the external clock.
- R3: SPI mode 0 is used. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises.
- R4: A conversion has exactly 24 SCLK high pulses with cs_n_o held low throughout. The second and third bytes sent are 0x00.
- R5: result_o = {RB2[5:0], RB3[7:6]}, where RB2 and RB3 are the second and third received bytes (MSB first). RB1 and all other bits have no effect on it.
- R6: Each SCLK high phase lasts div_i+1 system clocks, and so does each ordinary low phase. div_i is captured when the start request is accepted.
- R7: Between byte 1 and byte 2, and between byte 2 and byte 3, SCLK stays low for gap_i extra clocks. A gap_i of 0 adds no delay.
- R8: done_o pulses for one cycle in the cycle where cs_n_o returns high. result_o and err_o are updated at that point and hold until the next done pulse.
- R9: A start_i request made while busy_o is 1 is ignored. The conversion in progress is not changed, and no second conversion follows it.
- R10: err_o is 1 with a done pulse if the conversion's busy time exceeded BUDGET_CYC clocks, and is 0 otherwise.
- R11: A start_i request sampled while idle makes busy_o 1 and cs_n_o 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| chan_i | input | 3 | Channel field for the control byte |
| unipolar_i | input | 1 | 1 = unipolar, 0 = bipolar |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| div_i | input | DIV_W | SCLK half period minus one, in clocks |
| gap_i | input | GAP_W | Idle clocks between bytes |
| miso_i | input | 1 | Serial data from the ADC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Realigned conversion result |
| err_o | output | 1 | Time budget exceeded on last conversion |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the ADC |

## Verification
On every cycle, the assertions check the following:
- chip select tracks busy;
- SCLK is never high with chip select released;
- MOSI holds steady across each SCLK high phase;
- done is a single-cycle pulse that ends a busy period;
- a busy period begins only after a start request;
- exactly 24 rising edges occur between acceptance and done.

The bench scenarios are what show the data path. They cover the control-byte encoding, the realignment of the result across the byte boundary and the masking of pad bits, the measured SCLK phase and gap widths, the rejected mid-conversion start and the watchdog error with its clearing on the next conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int FRAME_BITS = 24;
  localparam int BYTE_BITS  = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_GAP,
    S_TAIL
  } seq_state_t;

  // Control byte: start, channel, unipolar, single-ended, two external-clock ones
  function automatic logic [7:0] build_ctrl(logic [2:0] ch, logic uni, logic sgl);
    return {1'b1, ch, uni, sgl, 2'b11};
  endfunction

  // Result straddles the second and third reply bytes
  function automatic logic [7:0] realign(logic [7:0] rb2, logic [7:0] rb3);
    return {rb2[5:0], rb3[7:6]};
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  input  logic         tx_shift_i,
  input  logic         rx_shift_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [N-1:0] rx_o
);

  logic [N-1:0] tx_q;
  logic [N-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i) begin
        tx_q <= load_val_i;
        rx_q <= '0;
      end else begin
        if (tx_shift_i) tx_q <= {tx_q[N-2:0], 1'b0};
        if (rx_shift_i) rx_q <= {rx_q[N-2:0], miso_i};
      end
    end
  end

  assign mosi_o = tx_q[N-1];
  assign rx_o   = rx_q;

endmodule

// File: rtl/adc_seq_wdog.sv
module adc_seq_wdog #(
  parameter int BUDGET_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic over_o
);

  localparam int CW = $clog2(BUDGET_CYC + 2);
  localparam logic [CW-1:0] SAT = CW'(BUDGET_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && cnt_q != SAT) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign over_o = (cnt_q > CW'(BUDGET_CYC));

endmodule

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq
  import adc_seq_pkg::*;
#(
  parameter int DIV_W      = 10,
  parameter int GAP_W      = 8,
  parameter int BUDGET_CYC = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       chan_i,
  input  logic             unipolar_i,
  input  logic             single_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       result_o,
  output logic             err_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o
);

  localparam int TW = (DIV_W + 1 > GAP_W) ? DIV_W + 1 : GAP_W;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  seq_state_t       st_q;
  logic [BW-1:0]    bit_q;
  logic [TW-1:0]    half_q;
  logic [GAP_W-1:0] gap_q;
  logic             cs_n_q, sclk_q, done_q, err_q;
  logic [7:0]       res_q;

  // Named internal events
  logic accept, rise_ev, fall_ev, byte_end, last_fall, gap_end, finish, gap_sel;
  logic t_zero, t_load;
  logic [TW-1:0] t_len;
  logic [FRAME_BITS-1:0] rx_w;
  logic wd_over;

  assign accept    = (st_q == S_IDLE) && start_i;
  assign rise_ev   = (st_q == S_LOW)  && t_zero;
  assign fall_ev   = (st_q == S_HIGH) && t_zero;
  assign last_fall = fall_ev && (bit_q == LAST_BIT);
  assign byte_end  = fall_ev && (bit_q[2:0] == 3'd7) && !last_fall;
  assign gap_sel   = byte_end && (gap_q != '0);
  assign gap_end   = (st_q == S_GAP)  && t_zero;
  assign finish    = (st_q == S_TAIL) && t_zero;

  always_comb begin
    t_load = accept || rise_ev || fall_ev || gap_end;
    t_len  = half_q;
    if (accept)       t_len = TW'(div_i) + TW'(1);
    else if (gap_sel) t_len = TW'(gap_q);
  end

  adc_seq_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (t_load),
    .len_i  (t_len),
    .zero_o (t_zero)
  );

  adc_seq_shift #(.N(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i ({build_ctrl(chan_i, unipolar_i, single_i), 16'h0000}),
    .tx_shift_i (fall_ev && !last_fall),
    .rx_shift_i (rise_ev),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_o       (rx_w)
  );

  adc_seq_wdog #(.BUDGET_CYC(BUDGET_CYC)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .en_i   (busy_o),
    .over_o (wd_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      bit_q  <= '0;
      half_q <= TW'(1);
      gap_q  <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (accept) begin
          st_q   <= S_LOW;
          bit_q  <= '0;
          half_q <= TW'(div_i) + TW'(1);
          gap_q  <= gap_i;
          cs_n_q <= 1'b0;
        end
        S_LOW: if (rise_ev) begin
          st_q   <= S_HIGH;
          sclk_q <= 1'b1;
        end
        S_HIGH: if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_fall) begin
            st_q <= S_TAIL;
          end else begin
            bit_q <= bit_q + BW'(1);
            st_q  <= gap_sel ? S_GAP : S_LOW;
          end
        end
        S_GAP: if (gap_end) st_q <= S_LOW;
        S_TAIL: if (finish) begin
          st_q   <= S_IDLE;
          cs_n_q <= 1'b1;
          done_q <= 1'b1;
          err_q  <= wd_over;
          res_q  <= realign(rx_w[15:8], rx_w[7:0]);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
  assign err_o    = err_q;
  assign cs_n_o   = cs_n_q;
  assign sclk_o   = sclk_q;

endmodule

// File: rtl/adc_xfer_seq_chk.sv
module adc_xfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic accept_ev,
  input logic sample_ev
);

  logic [5:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rises_q <= '0;
    else if (accept_ev) rises_q <= '0;
    else if (sample_ev) rises_q <= rises_q + 6'd1;
  end

  p_cs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !cs_n_o);
  p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n_o);
  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  p_sclk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> !cs_n_o);
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_pulse_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rises_q == 6'd24));

endmodule

bind adc_xfer_seq adc_xfer_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cs_n_o    (cs_n_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .accept_ev (accept),
  .sample_ev (rise_ev)
);

// File: tb/adc_xfer_seq_tb_top.sv
module adc_xfer_seq_tb_top;

  localparam int DIV_W  = 10;
  localparam int GAP_W  = 8;
  localparam int BUDGET = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic uni = 1'b0, sgl = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic [GAP_W-1:0] gap = '0;
  logic miso;
  logic busy, done, err, cs_n, sclk, mosi;
  logic [7:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  adc_xfer_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W), .BUDGET_CYC(BUDGET)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan),
    .unipolar_i(uni), .single_i(sgl), .div_i(div), .gap_i(gap),
    .miso_i(miso), .busy_o(busy), .done_o(done), .result_o(result),
    .err_o(err), .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi)
  );

  // ADC model and link monitor, all on the falling system clock
  logic [23:0] reply = '0;
  logic [23:0] mosi_cap = '0;
  int fcnt = 0, rises = 0, run = 0, hi_w = 0, lo2 = 0, lo9 = 0, lo17 = 0;
  logic prev_sclk = 1'b0;

  assign miso = (cs_n || fcnt >= 24) ? 1'b0 : reply[23 - fcnt];

  always @(negedge clk) begin
    if (cs_n) begin
      fcnt = 0; rises = 0; run = 0; prev_sclk = 1'b0;
    end else if (sclk != prev_sclk) begin
      if (sclk) begin
        rises = rises + 1;
        if (rises == 2)  lo2  = run;
        if (rises == 9)  lo9  = run;
        if (rises == 17) lo17 = run;
        mosi_cap = {mosi_cap[22:0], mosi};
      end else begin
        hi_w = run;
        fcnt = fcnt + 1;
      end
      run = 1;
      prev_sclk = sclk;
    end else begin
      run = run + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl(logic [2:0] c, logic u, logic s);
    logic [7:0] b;
    b[7] = 1'b1; b[6:4] = c; b[3] = u; b[2] = s; b[1] = 1'b1; b[0] = 1'b1;
    return b;
  endfunction

  int last_rises = 0;

  // Launch a conversion and wait for its done pulse
  task automatic run_conv(logic [2:0] c, logic u, logic s, int d, int g,
                          logic [23:0] rep);
    int waitc = 0;
    @(negedge clk);
    chan = c; uni = u; sgl = s; div = DIV_W'(d); gap = GAP_W'(g); reply = rep;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waitc < 60000) begin
      @(negedge clk);
      waitc++;
      if (rises != 0) last_rises = rises;
    end
    check("R8 done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset();
    check("R1 cs_n", {31'd0, cs_n}, 32'd1);
    check("R1 sclk", {31'd0, sclk}, 32'd0);
    check("R1 mosi", {31'd0, mosi}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 err",  {31'd0, err},  32'd0);
    check("R1 result", {24'd0, result}, 32'd0);
  endtask

  task automatic t_accept();
    @(negedge clk);
    chan = 3'd2; uni = 1'b1; sgl = 1'b1; div = 10'd3; gap = 8'd0; reply = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", {31'd0, busy}, 32'd1);
    check("R11 cs low after start", {31'd0, cs_n}, 32'd0);
    while (!done) @(negedge clk);
  endtask

  task automatic t_basic(logic [2:0] c, logic u, logic s, logic [7:0] res,
                         logic [7:0] rb1);
    run_conv(c, u, s, 1, 0, {rb1, 2'b00, res[7:2], res[1:0], 6'b0});
    check("R2 control byte", {24'd0, mosi_cap[23:16]}, {24'd0, exp_ctrl(c, u, s)});
    check("R4 zero bytes", {16'd0, mosi_cap[15:0]}, 32'd0);
    check("R4 sclk pulses", last_rises, 32'd24);
    check("R5 result", {24'd0, result}, {24'd0, res});
    check("R3 cs high at done", {31'd0, cs_n}, 32'd1);
  endtask

  task automatic t_pad_ignore();
    // ones in RB1 and every pad bit must not reach the result
    run_conv(3'd5, 1'b0, 1'b0, 0, 0, {8'hFF, 2'b11, 6'b010011, 2'b10, 6'b111111});
    check("R5 pad bits ignored", {24'd0, result}, 32'h4E);
  endtask

  task automatic t_div();
    run_conv(3'd1, 1'b1, 1'b0, 4, 0, {8'h00, 8'h2A, 8'h80});
    check("R6 high width", hi_w, 32'd5);
    check("R6 low width", lo2, 32'd5);
    check("R7 no gap", lo9, 32'd5);
    check("R5 result div", {24'd0, result}, 32'hAA);
  endtask

  task automatic t_gap();
    run_conv(3'd6, 1'b1, 1'b1, 2, 7, {8'h55, 8'h3F, 8'hC0});
    check("R7 gap byte1-2", lo9, 32'd10);
    check("R7 gap byte2-3", lo17, 32'd10);
    check("R6 low width gap run", lo2, 32'd3);
    check("R5 result gap", {24'd0, result}, 32'hFF);
  endtask

  task automatic t_busy_start();
    int waitc = 0;
    @(negedge clk);
    chan = 3'd3; uni = 1'b0; sgl = 1'b1; div = 10'd2; gap = 8'd0;
    reply = {8'h00, 2'b00, 6'b100000, 2'b01, 6'b0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chan = 3'd7; uni = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waitc < 60000) begin @(negedge clk); waitc++; end
    check("R9 ctrl unchanged", {24'd0, mosi_cap[23:16]}, {24'd0, exp_ctrl(3'd3, 1'b0, 1'b1)});
    check("R9 result", {24'd0, result}, 32'h81);
    repeat (10) @(negedge clk);
    check("R9 no second conversion", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_hold();
    logic [7:0] r;
    r = result;
    repeat (15) @(negedge clk);
    check("R8 done single cycle", {31'd0, done}, 32'd0);
    check("R8 result held", {24'd0, result}, {24'd0, r});
  endtask

  task automatic t_budget();
    run_conv(3'd0, 1'b1, 1'b1, 400, 0, {8'h00, 8'h01, 8'h40});
    check("R10 err over budget", {31'd0, err}, 32'd1);
    check("R5 result slow", {24'd0, result}, 32'h05);
    repeat (5) @(negedge clk);
    check("R8 err held", {31'd0, err}, 32'd1);
    run_conv(3'd0, 1'b1, 1'b1, 1, 3, {8'h00, 8'h01, 8'h40});
    check("R10 err clear within budget", {31'd0, err}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_accept();
    t_basic(3'd7, 1'b1, 1'b1, 8'hC3, 8'hA5);
    t_basic(3'd0, 1'b0, 1'b0, 8'h01, 8'h00);
    t_basic(3'd4, 1'b1, 1'b0, 8'h80, 8'hFF);
    t_hold();
    t_pad_ignore();
    t_div();
    t_gap();
    t_busy_start();
    t_budget();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule